// File: doc/BRIEF.md
# Paged Packet Buffer Manager

This block manages a shared on-chip packet memory for a 10 Mb/s Ethernet controller. The memory is 6 KB in total, split into 24 pages of 256 bytes. The block hands out whole pages to packets and takes them back. Each packet is known by a packet number, which is the index of its first page. The block does not hold the packet memory itself. It computes the physical byte addresses that the memory needs.

There are two packet-number queues, one for transmit and one for receive. They run independently, so the MAC can work through a chain of back-to-back packets in either direction without the CPU stepping in. When a packet completes, the block writes a status word into the first two bytes of that packet's own first page.

The host reads and writes packet data through a fixed window. The window has a logical offset that walks the packet's page chain, so bytes on different pages look contiguous. The window always shows two adjacent bytes, which allows a 16-bit transfer at any alignment.

The page allocator is a state machine with these states:
- IDLE waits for work. A start with enough free pages goes to GRAB. A start without enough free pages goes to DONE with the fail flag set. A release goes to FREE.
- GRAB takes one page per cycle, always the lowest free index. After the last page it goes to DONE.
- FREE clears every page owned by the given packet number in one cycle, then returns to IDLE.
- DONE presents the result for one cycle, then returns to IDLE.

The window cursor is a second state machine with these states:
- READY holds a valid position. From READY, `win_set` goes to WALK when the page hop count is non-zero.
- WALK follows one page link per cycle. It returns to READY when the hop count reaches zero.

Top module: `pktbuf_mgr`

## Requirements
- R1: The memory has 24 pages of 256 bytes each. After reset:
  - every page is free;
  - both queues are empty and neither is full;
  - `irq_rx` and `irq_tx` are low;
  - `cmd_ready` is high.
- R2: An allocation of length L takes max(1, ceil(L/256)) pages. The pages are the lowest free indices, taken in ascending order. The packet number is the first page taken. The result is a one-cycle pulse with the fail flag at 0:
  - for a host allocation, `res_valid` with `res_fail` low;
  - for a MAC receive allocation, `rx_grant`.
- R3: When the pages needed exceed the free pages, nothing changes in the page pool. A host allocation reports `res_fail`=1 with `res_pkt`=0. A MAC receive allocation pulses `rx_drop` instead of `rx_grant`, and the frame is dropped.
- R4: A release frees every page owned by the given packet number. A release of a number that owns no page changes nothing.
- R5: A pending MAC receive allocation has priority over host commands. `cmd_ready` is low while `rx_alloc_req` is high and while the allocator is busy.
- R6: Receive queue behaviour:
  - `rx_done` pushes its packet number;
  - `rx_head` shows the oldest entry;
  - host op RX_POP (3'd4) removes the oldest entry;
  - `irq_rx` equals "receive queue not empty";
  - the queue is 24 deep, and a push while full is ignored.
- R7: Transmit queue behaviour:
  - host op TX_ENQ (3'd3) pushes `cmd_pkt`;
  - `tx_deq` pops the oldest entry;
  - `tx_head` shows the oldest entry, with `tx_empty` and `tx_full` flags;
  - the queue is 24 deep, and a push while full is ignored;
  - transmit and receive queue operations can happen in the same cycle.
- R8: Status write-back happens one cycle after `rx_done` (or `tx_done`). The matching `stat_*_we` pulses with address = packet number × 256, which is byte 0 of the packet's first page, and data = the reported status word.
- R9: Transmit interrupt:
  - with `tx_chain_mode`=0, every `tx_done` sets `irq_tx`;
  - with `tx_chain_mode`=1, `tx_done` sets `irq_tx` only if the transmit queue is empty at that cycle;
  - host op TX_ACK (3'd5) clears `irq_tx`.
- R10: `win_set` loads a packet number and a logical offset. `win_busy` is then high for offset/256 cycles. After that:
  - `win_addr0` is the physical address of the logical byte;
  - `win_addr1` is the physical address of the next logical byte, which is on the next page of the chain when the offset is 255 within a page.
- R11: `win_adv` in READY advances the logical offset by 2 and follows the page chain across page boundaries.
- R12: Host op codes are ALLOC=3'd1 (uses `cmd_len`), RELEASE=3'd2 (uses `cmd_pkt`), TX_ENQ=3'd3, RX_POP=3'd4 and TX_ACK=3'd5. A command is taken when both `cmd_valid` and `cmd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_chain_mode | input | 1 | 1: one transmit interrupt per finished chain |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Host operation code |
| cmd_len | input | 11 | Byte length for ALLOC |
| cmd_pkt | input | 5 | Packet number for RELEASE / TX_ENQ |
| cmd_ready | output | 1 | Host command can be taken |
| res_valid | output | 1 | Host allocation result pulse |
| res_pkt | output | 5 | Allocated packet number |
| res_fail | output | 1 | Host allocation failed |
| rx_alloc_req | input | 1 | MAC asks for receive pages; held until answered |
| rx_alloc_len | input | 11 | Receive frame length |
| rx_grant | output | 1 | Receive allocation succeeded |
| rx_grant_pkt | output | 5 | Packet number for the received frame |
| rx_drop | output | 1 | Receive allocation failed, frame dropped |
| rx_done | input | 1 | Received packet complete |
| rx_done_pkt | input | 5 | Packet number of completed receive |
| rx_done_stat | input | 16 | Receive status word |
| tx_deq | input | 1 | MAC takes the head of the transmit queue |
| tx_head | output | 5 | Oldest transmit packet number |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_done | input | 1 | Transmit of a packet complete |
| tx_done_pkt | input | 5 | Packet number of completed transmit |
| tx_done_stat | input | 16 | Transmit status word |
| stat_rx_we | output | 1 | Receive status write strobe |
| stat_rx_addr | output | 13 | Receive status byte address |
| stat_rx_data | output | 16 | Receive status word |
| stat_tx_we | output | 1 | Transmit status write strobe |
| stat_tx_addr | output | 13 | Transmit status byte address |
| stat_tx_data | output | 16 | Transmit status word |
| win_set | input | 1 | Load window position |
| win_pkt | input | 5 | Window packet number |
| win_off | input | 11 | Window logical byte offset |
| win_adv | input | 1 | Advance window by two bytes |
| win_busy | output | 1 | Window walking the page chain |
| win_addr0 | output | 13 | Physical address of current byte |
| win_addr1 | output | 13 | Physical address of following byte |
| rx_head | output | 5 | Oldest receive packet number |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| irq_rx | output | 1 | Receive interrupt (queue not empty) |
| irq_tx | output | 1 | Transmit interrupt, sticky until TX_ACK |

## Verification
A wrong bit in the page bitmap shows up at the very next allocation. It appears as a packet number that differs from the lowest-free model, or as a fail flag that is wrong compared with the model's free count. A bad page link shows up only when the window crosses a page boundary. It appears as a wrong `win_addr1` at an offset of 255 or as a wrong address after a hop, so the bench probes offsets right at page edges. Queue pointer errors show up as an out-of-order `rx_head`/`tx_head` on the next pop, or as wrong full/empty flags at depth 24.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RELEASE = 3'd2,
        OP_TX_ENQ  = 3'd3,
        OP_RX_POP  = 3'd4,
        OP_TX_ACK  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        AL_IDLE,
        AL_GRAB,
        AL_FREE,
        AL_DONE
    } al_state_e;

    typedef enum logic {
        WN_READY,
        WN_WALK
    } wn_state_e;
endpackage

// File: rtl/pbm_pkt_fifo.sv
module pbm_pkt_fifo #(
    parameter  int DEPTH = 24,
    parameter  int W     = 5,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));
    assert_push_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pbm_page_alloc.sv
module pbm_page_alloc
    import pbm_pkg::*;
#(
    parameter  int NPAGE  = 24,
    parameter  int NEED_W = 4,
    localparam int IDX_W  = $clog2(NPAGE),
    localparam int CNT_W  = $clog2(NPAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NEED_W-1:0] need,
    input  logic              rel,
    input  logic [IDX_W-1:0]  rel_pkt,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [IDX_W-1:0]  lk_nxt,
    output logic              idle,
    output logic              done,
    output logic [IDX_W-1:0]  done_pkt,
    output logic              done_fail
);
    al_state_e           state, nxt;
    logic [NPAGE-1:0]    used;
    logic [IDX_W-1:0]    owner [NPAGE];
    logic [IDX_W-1:0]    link  [NPAGE];
    logic [IDX_W-1:0]    head, prev, rel_q, low_idx;
    logic [NEED_W-1:0]   remain;
    logic                fail_q, first_q, any_free, fits;
    logic [CNT_W-1:0]    free_cnt;

    // lowest free page and free page count
    always_comb begin
        low_idx  = '0;
        any_free = 1'b0;
        free_cnt = '0;
        for (int i = NPAGE - 1; i >= 0; i--) begin
            if (!used[i]) begin
                low_idx  = IDX_W'(i);
                any_free = 1'b1;
                free_cnt = free_cnt + 1'b1;
            end
        end
    end

    assign fits   = (32'(need) <= 32'(free_cnt));
    assign lk_nxt = (32'(lk_idx) < NPAGE) ? link[lk_idx] : '0;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            AL_IDLE: begin
                if (start)    nxt = fits ? AL_GRAB : AL_DONE;
                else if (rel) nxt = AL_FREE;
            end
            AL_GRAB: if (remain == NEED_W'(1)) nxt = AL_DONE;
            AL_FREE: nxt = AL_IDLE;
            AL_DONE: nxt = AL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= AL_IDLE;
        else        state <= nxt;
    end

    // page tables and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used    <= '0;
            head    <= '0;
            prev    <= '0;
            rel_q   <= '0;
            remain  <= '0;
            fail_q  <= 1'b0;
            first_q <= 1'b0;
            for (int i = 0; i < NPAGE; i++) begin
                owner[i] <= '0;
                link[i]  <= '0;
            end
        end else begin
            unique case (state)
                AL_IDLE: begin
                    if (start) begin
                        remain  <= need;
                        fail_q  <= !fits;
                        first_q <= 1'b1;
                    end else if (rel) begin
                        rel_q <= rel_pkt;
                    end
                end
                AL_GRAB: begin
                    used[low_idx]  <= 1'b1;
                    owner[low_idx] <= first_q ? low_idx : head;
                    link[low_idx]  <= low_idx;
                    if (first_q) head <= low_idx;
                    else         link[prev] <= low_idx;
                    prev    <= low_idx;
                    first_q <= 1'b0;
                    remain  <= remain - 1'b1;
                end
                AL_FREE: begin
                    for (int i = 0; i < NPAGE; i++)
                        if (used[i] && owner[i] == rel_q) used[i] <= 1'b0;
                end
                AL_DONE: ;
            endcase
        end
    end

    assign idle      = (state == AL_IDLE);
    assign done      = (state == AL_DONE);
    assign done_fail = fail_q;
    assign done_pkt  = fail_q ? '0 : head;

    assert_grab_has_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AL_GRAB) |-> any_free);
    assert_fail_keeps_pool_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AL_DONE && fail_q) |-> $stable(used));
    assert_release_no_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AL_FREE) |=> (free_cnt >= $past(free_cnt)));
endmodule

// File: rtl/pbm_window.sv
module pbm_window
    import pbm_pkg::*;
#(
    parameter  int NPAGE    = 24,
    parameter  int PG_BYTES = 256,
    parameter  int LEN_W    = 11,
    localparam int IDX_W    = $clog2(NPAGE),
    localparam int OFF_W    = $clog2(PG_BYTES),
    localparam int HOP_W    = LEN_W - OFF_W,
    localparam int ADDR_W   = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [IDX_W-1:0]  set_pkt,
    input  logic [LEN_W-1:0]  set_off,
    input  logic              adv,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  lk_nxt,
    output logic              busy,
    output logic [ADDR_W-1:0] addr0,
    output logic [ADDR_W-1:0] addr1
);
    wn_state_e        state, nxt;
    logic [IDX_W-1:0] cur;
    logic [OFF_W-1:0] boff;
    logic [HOP_W-1:0] hops;
    logic [OFF_W:0]   adv_sum;

    assign adv_sum = {1'b0, boff} + (OFF_W + 1)'(2);

    always_comb begin
        nxt = state;
        unique case (state)
            WN_READY: if (set && set_off[LEN_W-1:OFF_W] != '0) nxt = WN_WALK;
            WN_WALK:  if (hops == HOP_W'(1)) nxt = WN_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WN_READY;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            boff <= '0;
            hops <= '0;
        end else begin
            unique case (state)
                WN_READY: begin
                    if (set) begin
                        cur  <= set_pkt;
                        boff <= set_off[OFF_W-1:0];
                        hops <= set_off[LEN_W-1:OFF_W];
                    end else if (adv) begin
                        boff <= adv_sum[OFF_W-1:0];
                        if (adv_sum[OFF_W]) cur <= lk_nxt;
                    end
                end
                WN_WALK: begin
                    cur  <= lk_nxt;
                    hops <= hops - 1'b1;
                end
            endcase
        end
    end

    assign lk_idx = cur;
    assign busy   = (state == WN_WALK);
    assign addr0  = {cur, boff};
    assign addr1  = (boff == '1) ? {lk_nxt, {OFF_W{1'b0}}} : {cur, boff + 1'b1};

    assert_walk_has_hops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WN_WALK) |-> (hops != '0));
    assert_adv_steps_two_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WN_READY && adv && !set) |=> (boff == $past(boff) + OFF_W'(2)));
endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr
    import pbm_pkg::*;
#(
    parameter  int NPAGE    = 24,
    parameter  int PG_BYTES = 256,
    parameter  int LEN_W    = 11,
    parameter  int QDEPTH   = 24,
    parameter  int STAT_W   = 16,
    localparam int IDX_W    = $clog2(NPAGE),
    localparam int OFF_W    = $clog2(PG_BYTES),
    localparam int ADDR_W   = IDX_W + OFF_W,
    localparam int NEED_W   = LEN_W - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_chain_mode,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [IDX_W-1:0]  cmd_pkt,
    output logic              cmd_ready,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_pkt,
    output logic              res_fail,
    input  logic              rx_alloc_req,
    input  logic [LEN_W-1:0]  rx_alloc_len,
    output logic              rx_grant,
    output logic [IDX_W-1:0]  rx_grant_pkt,
    output logic              rx_drop,
    input  logic              rx_done,
    input  logic [IDX_W-1:0]  rx_done_pkt,
    input  logic [STAT_W-1:0] rx_done_stat,
    input  logic              tx_deq,
    output logic [IDX_W-1:0]  tx_head,
    output logic              tx_empty,
    output logic              tx_full,
    input  logic              tx_done,
    input  logic [IDX_W-1:0]  tx_done_pkt,
    input  logic [STAT_W-1:0] tx_done_stat,
    output logic              stat_rx_we,
    output logic [ADDR_W-1:0] stat_rx_addr,
    output logic [STAT_W-1:0] stat_rx_data,
    output logic              stat_tx_we,
    output logic [ADDR_W-1:0] stat_tx_addr,
    output logic [STAT_W-1:0] stat_tx_data,
    input  logic              win_set,
    input  logic [IDX_W-1:0]  win_pkt,
    input  logic [LEN_W-1:0]  win_off,
    input  logic              win_adv,
    output logic              win_busy,
    output logic [ADDR_W-1:0] win_addr0,
    output logic [ADDR_W-1:0] win_addr1,
    output logic [IDX_W-1:0]  rx_head,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic              a_idle, a_done, a_fail, a_start, a_rel;
    logic [IDX_W-1:0]  a_pkt, lk_idx, lk_nxt;
    logic [NEED_W-1:0] need;
    logic [LEN_W-1:0]  alloc_len;
    logic              cmd_fire, rx_pick, host_alloc, owner_rx_q;

    assign cmd_ready  = a_idle && !rx_alloc_req;
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign rx_pick    = a_idle && rx_alloc_req;
    assign host_alloc = cmd_fire && (cmd_op == OP_ALLOC);
    assign a_start    = rx_pick || host_alloc;
    assign a_rel      = cmd_fire && (cmd_op == OP_RELEASE);
    assign alloc_len  = rx_pick ? rx_alloc_len : cmd_len;

    // pages needed: ceil(len / page), never below one
    always_comb begin
        need = {1'b0, alloc_len[LEN_W-1:OFF_W]} + NEED_W'(|alloc_len[OFF_W-1:0]);
        if (need == '0) need = NEED_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       owner_rx_q <= 1'b0;
        else if (a_start) owner_rx_q <= rx_pick;
    end

    pbm_page_alloc #(.NPAGE(NPAGE), .NEED_W(NEED_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .start(a_start), .need(need),
        .rel(a_rel), .rel_pkt(cmd_pkt), .lk_idx(lk_idx), .lk_nxt(lk_nxt),
        .idle(a_idle), .done(a_done), .done_pkt(a_pkt), .done_fail(a_fail)
    );

    assign res_valid    = a_done && !owner_rx_q;
    assign res_pkt      = a_pkt;
    assign res_fail     = a_fail;
    assign rx_grant     = a_done && owner_rx_q && !a_fail;
    assign rx_drop      = a_done && owner_rx_q && a_fail;
    assign rx_grant_pkt = a_pkt;

    pbm_pkt_fifo #(.DEPTH(QDEPTH), .W(IDX_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_done), .din(rx_done_pkt),
        .pop(cmd_fire && (cmd_op == OP_RX_POP)),
        .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    pbm_pkt_fifo #(.DEPTH(QDEPTH), .W(IDX_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(cmd_fire && (cmd_op == OP_TX_ENQ)),
        .din(cmd_pkt), .pop(tx_deq),
        .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    pbm_window #(.NPAGE(NPAGE), .PG_BYTES(PG_BYTES), .LEN_W(LEN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .set(win_set), .set_pkt(win_pkt),
        .set_off(win_off), .adv(win_adv), .lk_idx(lk_idx), .lk_nxt(lk_nxt),
        .busy(win_busy), .addr0(win_addr0), .addr1(win_addr1)
    );

    assign irq_rx = !rx_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx       <= 1'b0;
            stat_rx_we   <= 1'b0;
            stat_rx_addr <= '0;
            stat_rx_data <= '0;
            stat_tx_we   <= 1'b0;
            stat_tx_addr <= '0;
            stat_tx_data <= '0;
        end else begin
            if (tx_done && (!tx_chain_mode || tx_empty)) irq_tx <= 1'b1;
            else if (cmd_fire && (cmd_op == OP_TX_ACK))   irq_tx <= 1'b0;
            stat_rx_we   <= rx_done;
            stat_rx_addr <= {rx_done_pkt, {OFF_W{1'b0}}};
            stat_rx_data <= rx_done_stat;
            stat_tx_we   <= tx_done;
            stat_tx_addr <= {tx_done_pkt, {OFF_W{1'b0}}};
            stat_tx_data <= tx_done_stat;
        end
    end

    assert_irq_tx_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> $past(tx_done));
    assert_rx_stat_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rx_we |-> $past(rx_done));
    assert_rx_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_alloc_req |-> !cmd_ready);
endmodule

// File: tb/test_pktbuf_mgr.sv
module test_pktbuf_mgr;
    import pbm_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, tx_chain_mode = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [10:0] cmd_len = '0;
    logic [4:0] cmd_pkt = '0;
    logic cmd_ready, res_valid, res_fail;
    logic [4:0] res_pkt;
    logic rx_alloc_req = 1'b0;
    logic [10:0] rx_alloc_len = '0;
    logic rx_grant, rx_drop;
    logic [4:0] rx_grant_pkt;
    logic rx_done = 1'b0;
    logic [4:0] rx_done_pkt = '0;
    logic [15:0] rx_done_stat = '0;
    logic tx_deq = 1'b0;
    logic [4:0] tx_head;
    logic tx_empty, tx_full;
    logic tx_done = 1'b0;
    logic [4:0] tx_done_pkt = '0;
    logic [15:0] tx_done_stat = '0;
    logic stat_rx_we, stat_tx_we;
    logic [12:0] stat_rx_addr, stat_tx_addr;
    logic [15:0] stat_rx_data, stat_tx_data;
    logic win_set = 1'b0, win_adv = 1'b0;
    logic [4:0] win_pkt = '0;
    logic [10:0] win_off = '0;
    logic win_busy;
    logic [12:0] win_addr0, win_addr1;
    logic [4:0] rx_head;
    logic rx_empty, rx_full, irq_rx, irq_tx;

    pktbuf_mgr i_pktbuf_mgr (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, bad = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference page model
    bit used_m[24];
    int owner_m[24];
    int plist[24][8];

    function automatic int need_of(input int len);
        int n = (len + 255) / 256;
        return (n == 0) ? 1 : n;
    endfunction

    task automatic model_alloc(input int len, output int pkt, output bit fail);
        int n = need_of(len), nfree = 0, k = 0;
        for (int i = 0; i < 24; i++) if (!used_m[i]) nfree++;
        pkt = 0;
        fail = (n > nfree);
        if (!fail) begin
            for (int i = 0; i < 24 && k < n; i++) begin
                if (!used_m[i]) begin
                    if (k == 0) pkt = i;
                    used_m[i] = 1;
                    owner_m[i] = pkt;
                    plist[pkt][k] = i;
                    k++;
                end
            end
        end
    endtask

    function automatic int phys(input int pkt, input int off);
        return plist[pkt][off / 256] * 256 + off % 256;
    endfunction

    // scoreboard
    typedef struct { bit is_rx; int pkt; bit fail; } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (res_valid || rx_grant || rx_drop)) begin
            if (sbq.size() == 0) begin
                check("R2 unexpected result", 1, 0);
            end else begin
                e = sbq.pop_front();
                check("R5 result source", int'(rx_grant || rx_drop), int'(e.is_rx));
                check("R3 fail flag", e.is_rx ? int'(rx_drop) : int'(res_fail), int'(e.fail));
                if (!e.fail) check("R2 packet number", e.is_rx ? int'(rx_grant_pkt) : int'(res_pkt), e.pkt);
                else if (!e.is_rx) check("R3 pkt zero on fail", int'(res_pkt), 0);
            end
        end
    end

    task automatic host_cmd(input op_e op, input int len, input int pkt);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_len = 11'(len); cmd_pkt = 5'(pkt);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic host_alloc(input int len);
        int p; bit f;
        model_alloc(len, p, f);
        sbq.push_back('{1'b0, p, f});
        host_cmd(OP_ALLOC, len, 0);
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic host_release(input int pkt);
        for (int i = 0; i < 24; i++) if (used_m[i] && owner_m[i] == pkt) used_m[i] = 0;
        host_cmd(OP_RELEASE, 0, pkt);
    endtask

    task automatic mac_alloc(input int len);
        int p; bit f;
        model_alloc(len, p, f);
        sbq.push_back('{1'b1, p, f});
        @(negedge clk);
        rx_alloc_req = 1'b1; rx_alloc_len = 11'(len);
        #1 check("R5 host blocked during rx request", int'(cmd_ready), 0);
        do @(negedge clk); while (!(rx_grant || rx_drop));
        rx_alloc_req = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic win_probe(input int pkt, input int off, input int nadv);
        int busy_n = 0, o = off;
        @(negedge clk);
        win_set = 1'b1; win_pkt = 5'(pkt); win_off = 11'(off);
        @(negedge clk);
        win_set = 1'b0;
        while (win_busy) begin busy_n++; @(negedge clk); end
        check("R10 walk cycles", busy_n, off / 256);
        for (int k = 0; k <= nadv; k++) begin
            check("R10/R11 win_addr0", int'(win_addr0), phys(pkt, o));
            check("R10/R11 win_addr1", int'(win_addr1), phys(pkt, o + 1));
            if (k < nadv) begin
                win_adv = 1'b1;
                @(negedge clk);
                win_adv = 1'b0;
                o += 2;
            end
        end
    endtask

    task automatic rx_finish(input int pkt, input int stat);
        @(negedge clk);
        rx_done = 1'b1; rx_done_pkt = 5'(pkt); rx_done_stat = 16'(stat);
        @(negedge clk);
        rx_done = 1'b0;
        check("R8 rx status strobe", int'(stat_rx_we), 1);
        check("R8 rx status addr", int'(stat_rx_addr), pkt * 256);
        check("R8 rx status data", int'(stat_rx_data), stat);
    endtask

    task automatic tx_finish(input int pkt, input int stat, input int exp_irq);
        @(negedge clk);
        tx_done = 1'b1; tx_done_pkt = 5'(pkt); tx_done_stat = 16'(stat);
        @(negedge clk);
        tx_done = 1'b0;
        check("R8 tx status strobe", int'(stat_tx_we), 1);
        check("R8 tx status addr", int'(stat_tx_addr), pkt * 256);
        check("R8 tx status data", int'(stat_tx_data), stat);
        check("R9 irq_tx after tx_done", int'(irq_tx), exp_irq);
    endtask

    task automatic mac_deq();
        @(negedge clk);
        tx_deq = 1'b1;
        @(negedge clk);
        tx_deq = 1'b0;
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cmd_ready", int'(cmd_ready), 1);
        check("R1 irq_rx", int'(irq_rx), 0);
        check("R1 irq_tx", int'(irq_tx), 0);
        check("R1 rx_empty", int'(rx_empty), 1);
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 full flags", int'(rx_full || tx_full), 0);

        // R2 allocation, lowest pages first; R12 op codes
        host_alloc(600);
        host_alloc(256);
        host_alloc(0);
        host_alloc(1);
        // R4 release, then a fragmented chain
        host_release(3);
        host_alloc(1500);

        // R10 / R11 window across page boundaries
        win_probe(3, 255, 2);
        win_probe(3, 1021, 3);
        win_probe(0, 510, 2);

        // R3 / R5 MAC receive allocation and drop
        mac_alloc(2000);
        mac_alloc(1600);
        host_alloc(1300);
        host_alloc(1280);
        host_alloc(1);
        // R4 releasing a non-owner number leaves the pool full
        host_release(7);
        host_alloc(1);
        host_release(11);
        host_alloc(100);

        // R6 receive queue and R8 status
        rx_finish(11, 16'hA5C3);
        check("R6 rx_head", int'(rx_head), 11);
        check("R6 irq_rx set", int'(irq_rx), 1);
        rx_finish(0, 16'h1234);
        host_cmd(OP_RX_POP, 0, 0);
        check("R6 rx_head after pop", int'(rx_head), 0);
        host_cmd(OP_RX_POP, 0, 0);
        check("R6 rx empty after pops", int'(rx_empty), 1);
        check("R6 irq_rx clear", int'(irq_rx), 0);

        // R7 transmit queue, R9 per-packet interrupt
        tx_chain_mode = 1'b0;
        host_cmd(OP_TX_ENQ, 0, 3);
        host_cmd(OP_TX_ENQ, 0, 19);
        check("R7 tx_head", int'(tx_head), 3);
        @(negedge clk);
        tx_deq = 1'b1; rx_done = 1'b1; rx_done_pkt = 5'd19; rx_done_stat = 16'h0;
        @(negedge clk);
        tx_deq = 1'b0; rx_done = 1'b0;
        check("R7 tx pop with rx push", int'(tx_head), 19);
        check("R7 rx push with tx pop", int'(rx_head), 19);
        host_cmd(OP_RX_POP, 0, 0);
        tx_finish(3, 16'h0F0F, 1);
        host_cmd(OP_TX_ACK, 0, 0);
        check("R9 irq_tx ack", int'(irq_tx), 0);

        // R9 chain mode: one interrupt at end of chain
        tx_chain_mode = 1'b1;
        mac_deq();
        host_cmd(OP_TX_ENQ, 0, 4);
        tx_finish(19, 16'h0042, 0);
        mac_deq();
        tx_finish(4, 16'h0043, 1);
        host_cmd(OP_TX_ACK, 0, 0);
        check("R9 chain irq ack", int'(irq_tx), 0);

        // R7 depth 24 and full-push ignored
        for (int i = 0; i < 24; i++) host_cmd(OP_TX_ENQ, 0, i);
        check("R7 tx_full at 24", int'(tx_full), 1);
        host_cmd(OP_TX_ENQ, 0, 30);
        for (int i = 0; i < 24; i++) begin
            check("R7 tx order", int'(tx_head), i);
            mac_deq();
        end
        check("R7 extra push ignored", int'(tx_empty), 1);

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule